// File: doc/BRIEF.md
# Strided Block Address Generator

This block produces the byte address sequence for one side of a DMA transfer, either the reading side or the writing side. A single start pulse captures the starting address, a 22-bit total byte count, a stride-enable input and a 32-bit configuration word. The configuration word carries the unit size, the address movement mode, the block length and the stride. From the cycle after the start pulse, the block presents an address together with the unit-size code and holds valid high. Each accepted beat moves the address on. The final beat is marked with a last flag.

Four movement modes are available: increment, decrement, hold, and a wrapping burst. With stride enabled, the addresses are grouped into blocks of a programmable number of beats. When a block ends, the next block begins a stride distance (in bytes) past the start of the block that just finished. The block moves no data and has no bus protocol. It only generates addresses for a data path beside it.

Top module: `strided_addr_gen`

## Requirements
- R1: At start the configuration word is captured with the unit-size code in bits 31:30, the movement mode in bits 29:28, the block length in beats in bits 27:14 and the stride in bytes in bits 13:0. Later changes to the word have no effect until the next start.
- R2: size_out shows the captured unit-size code (0=1, 1=2, 2=4, 3=8 bytes) and does not change while a transfer is active.
- R3: In mode 0 (increment), each accepted beat adds the unit size to the address.
- R4: In mode 1 (decrement), each accepted beat subtracts the unit size from the address.
- R5: In mode 2 (hold), every beat uses the start address.
- R6: In mode 3 (burst) with a nonzero block length B, the address counts up by the unit size and returns to the start address after every B beats. When B is 0, burst behaves like increment.
- R7: When stride_en is high and B is nonzero, a new block begins after every B beats at the previous block's start plus the stride. Inside a block the address moves as the mode says, and burst moves like increment. When stride_en is low, the block and stride fields are ignored, except for the burst wrap in R6.
- R8: The beat count is the byte count divided by the unit size, rounded up. last is high only on the final beat, and a byte count of 0 gives no beats and valid stays low.
- R9: valid rises the cycle after start and stays high until the final beat is accepted, then falls. While beat_ready is low, the address holds.
- R10: A start during an active transfer abandons it and restarts from the new parameters.
- R11: After reset, valid and last are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load parameters and begin a transfer |
| cfg_word | input | 32 | Unit size, mode, block length, stride |
| stride_en | input | 1 | Enable block/stride addressing |
| base_addr | input | AW | Starting byte address |
| byte_count | input | 22 | Total bytes to transfer |
| beat_ready | input | 1 | Consumer accepts the current beat |
| addr_out | output | AW | Current beat address |
| size_out | output | 2 | Unit-size code of the current beat |
| valid | output | 1 | A beat is being offered |
| last | output | 1 | Current beat is the final one |

## Verification
Most internal faults in this block become visible on addr_out at the first accepted beat that uses the faulty state. A wrong step or sign shows on the second beat. A block counter that is off by one shows at the first block boundary, which is B+1 beats into the transfer. A remaining-beat counter that is wrong moves last, or leaves valid high after the final acceptance, so it is caught at the end of the transfer. A stall that advances the address shows up in the cycle right after beat_ready is low.

// File: rtl/strided_addr_gen.sv
module strided_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 22,
  parameter int FW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   cfg_word,
  input  logic          stride_en,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] byte_count,
  input  logic          beat_ready,
  output logic [AW-1:0] addr_out,
  output logic [1:0]    size_out,
  output logic          valid,
  output logic          last
);
  localparam logic [1:0] M_INC = 2'd0, M_DEC = 2'd1, M_HOLD = 2'd2, M_BURST = 2'd3;

  logic [1:0]    sz_q, mode_q;
  logic [FW-1:0] blk_q, str_q, inb_q;
  logic          se_q, valid_q;
  logic [AW-1:0] addr_q, bstart_q;
  logic [CW:0]   rem_q;

  wire [1:0]  sz_in   = cfg_word[31:30];
  wire [CW:0] padded  = {1'b0, byte_count} + ((CW+1)'(1) << sz_in) - (CW+1)'(1);
  wire [CW:0] beats   = padded >> sz_in;

  wire [AW-1:0] unit     = AW'(1) << sz_q;
  wire          wrap_en  = (blk_q != '0) && (se_q || mode_q == M_BURST);
  wire          blk_end  = wrap_en && (inb_q == blk_q - FW'(1));
  wire [AW-1:0] next_blk = bstart_q + (se_q ? AW'(str_q) : '0);
  wire          accept   = valid_q && beat_ready;

  logic [AW-1:0] stepped;
  always_comb begin
    case (mode_q)
      M_DEC:   stepped = addr_q - unit;
      M_HOLD:  stepped = addr_q;
      default: stepped = addr_q + unit;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sz_q <= '0; mode_q <= '0; blk_q <= '0; str_q <= '0; se_q <= 1'b0;
      addr_q <= '0; bstart_q <= '0; inb_q <= '0; rem_q <= '0; valid_q <= 1'b0;
    end else if (start) begin
      sz_q     <= sz_in;
      mode_q   <= cfg_word[29:28];
      blk_q    <= cfg_word[27:14];
      str_q    <= cfg_word[13:0];
      se_q     <= stride_en;
      addr_q   <= base_addr;
      bstart_q <= base_addr;
      inb_q    <= '0;
      rem_q    <= beats;
      valid_q  <= (beats != '0);
    end else if (accept) begin
      rem_q <= rem_q - (CW+1)'(1);
      if (rem_q == (CW+1)'(1)) valid_q <= 1'b0;
      if (blk_end) begin
        addr_q   <= next_blk;
        bstart_q <= next_blk;
        inb_q    <= '0;
      end else begin
        addr_q <= stepped;
        inb_q  <= inb_q + FW'(1);
      end
    end
  end

  assign addr_out = addr_q;
  assign size_out = sz_q;
  assign valid    = valid_q;
  assign last     = valid_q && (rem_q == (CW+1)'(1));
endmodule

module strided_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [31:0]   cfg_word,
  input logic          stride_en,
  input logic          beat_ready,
  input logic [AW-1:0] addr_out,
  input logic [1:0]    size_out,
  input logic          valid,
  input logic          last
);
  logic [1:0] c_mode;
  logic       c_se;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_mode <= '0; c_se <= 1'b0;
    end else if (start) begin
      c_mode <= cfg_word[29:28]; c_se <= stride_en;
    end
  end

  assert_last_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);
  assert_drop_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && beat_ready && last && !start) |=> !valid);
  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !beat_ready && !start) |=> (valid && $stable(addr_out)));
  assert_size_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !start) |=> (!valid || $stable(size_out)));
  assert_inc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && beat_ready && !last && !start && c_mode == 2'd0 && !c_se)
    |=> addr_out == $past(addr_out) + (AW'(1) << $past(size_out)));
  assert_hold_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && beat_ready && !last && !start && c_mode == 2'd2 && !c_se)
    |=> addr_out == $past(addr_out));
endmodule

bind strided_addr_gen strided_addr_gen_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word),
  .stride_en(stride_en), .beat_ready(beat_ready), .addr_out(addr_out),
  .size_out(size_out), .valid(valid), .last(last)
);

// File: tb/strided_addr_gen_tb.sv
`timescale 1ns/1ps
module strided_addr_gen_tb_top;
  localparam int AW = 32;

  typedef struct packed {
    logic [31:0] cfg;
    logic        se;
    logic [31:0] base;
    logic [21:0] cnt;
    logic        stall;
  } vec_t;

  function automatic logic [31:0] mk(int sz, int mode, int blk, int str);
    return {sz[1:0], mode[1:0], blk[13:0], str[13:0]};
  endfunction

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{mk(2,0,2,'h40),  1'b0, 32'h1000, 22'd16, 1'b0},
    '{mk(0,1,0,0),     1'b0, 32'h2000, 22'd5,  1'b1},
    '{mk(2,2,3,'h10),  1'b0, 32'h2800, 22'd10, 1'b0},
    '{mk(2,3,4,0),     1'b0, 32'h3000, 22'd40, 1'b1},
    '{mk(3,0,3,'h100), 1'b1, 32'h4000, 22'd56, 1'b0},
    '{mk(1,1,2,'h20),  1'b1, 32'h5000, 22'd9,  1'b1},
    '{mk(1,0,0,0),     1'b0, 32'h6002, 22'd1,  1'b0},
    '{mk(2,3,0,0),     1'b0, 32'h7000, 22'd12, 1'b0}
  };

  logic clk = 0, rst_n = 0, start = 0, stride_en = 0, beat_ready = 0;
  logic [31:0] cfg_word = '0;
  logic [AW-1:0] base_addr = '0;
  logic [21:0] byte_count = '0;
  logic [AW-1:0] addr_out;
  logic [1:0] size_out;
  logic valid, last;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  strided_addr_gen #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word),
    .stride_en(stride_en), .base_addr(base_addr), .byte_count(byte_count),
    .beat_ready(beat_ready), .addr_out(addr_out), .size_out(size_out),
    .valid(valid), .last(last)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int nbeats(vec_t v);
    int u = 1 << v.cfg[31:30];
    return (int'(v.cnt) + u - 1) / u;
  endfunction

  function automatic logic [31:0] exp_addr(vec_t v, int i);
    int u = 1 << v.cfg[31:30];
    int mode = v.cfg[29:28];
    int b = v.cfg[27:14];
    int s = v.cfg[13:0];
    logic [31:0] bs;
    int k;
    if (v.se && b != 0) begin
      bs = v.base + 32'((i / b) * s);
      k = i % b;
      case (mode)
        1: return bs - 32'(k * u);
        2: return bs;
        default: return bs + 32'(k * u);
      endcase
    end
    if (mode == 3 && b != 0) return v.base + 32'((i % b) * u);
    case (mode)
      1: return v.base - 32'(i * u);
      2: return v.base;
      default: return v.base + 32'(i * u);
    endcase
  endfunction

  function automatic string tag(vec_t v);
    if (v.se && v.cfg[27:14] != 0) return "R7";
    case (v.cfg[29:28])
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic pulse_start(vec_t v);
    cfg_word = v.cfg; stride_en = v.se; base_addr = v.base; byte_count = v.cnt;
    start = 1; beat_ready = 0;
    @(negedge clk);
    start = 0;
    cfg_word = ~v.cfg; base_addr = ~v.base;
  endtask

  task automatic run_beats(vec_t v, int first, int upto);
    int n = nbeats(v);
    int i = first;
    int cyc = 0;
    while (i < upto) begin
      check(valid === 1'b1, "R9 valid", valid, 1);
      check(addr_out === exp_addr(v, i), tag(v), addr_out, exp_addr(v, i));
      check(size_out === v.cfg[31:30], "R2 size", size_out, v.cfg[31:30]);
      check(last === (i == n - 1), "R8 last", last, (i == n - 1));
      beat_ready = !(v.stall && (cyc % 2 == 1));
      if (beat_ready) i++;
      cyc++;
      @(negedge clk);
    end
    beat_ready = 0;
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    check(valid === 1'b0 && last === 1'b0, "R11 reset", {valid, last}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      pulse_start(VEC[k]);
      run_beats(VEC[k], 0, nbeats(VEC[k]));
      check(valid === 1'b0, "R9 done", valid, 0);
      @(negedge clk);
    end

    // R8: zero byte count gives no beats
    begin
      vec_t z = '{mk(2,0,0,0), 1'b0, 32'h8000, 22'd0, 1'b0};
      pulse_start(z);
      for (int c = 0; c < 3; c++) begin
        check(valid === 1'b0, "R8 zero count", valid, 0);
        @(negedge clk);
      end
    end

    // R10: restart mid-transfer; R1 inputs scrambled after start (in pulse_start)
    pulse_start(VEC[0]);
    run_beats(VEC[0], 0, 2);
    pulse_start(VEC[4]);
    run_beats(VEC[4], 0, nbeats(VEC[4]));
    check(valid === 1'b0, "R10 restart done", valid, 0);

    // R1: stall long with changed inputs, address must not follow them
    pulse_start(VEC[3]);
    repeat (4) @(negedge clk);
    check(addr_out === 32'h3000, "R1 capture", addr_out, 32'h3000);
    run_beats(VEC[3], 0, nbeats(VEC[3]));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule